// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the settings that a clock synthesizer's dividers run from: a 9-bit feedback multiplier, a 2-bit output divide code and a 2-bit diagnostic select. Settings arrive from one of two sources. The first is a set of parallel pins, applied while an active-low parallel-enable input is held low and captured when that input rises. The second is a three-wire serial port made up of a serial clock, serial data and a load strobe. All port inputs are brought into one system clock domain through synchronizer flops before any edge is detected. The output frequency of the surrounding synthesizer is reference × M ÷ N. The dividers, the oscillator and the loop filter sit outside this block.

The serial frame is 14 bits long and is shifted in most significant bit first. It holds the two select bits, then one filler bit that is ignored, then the two N bits, then M from its top bit down to bit 0. The frame moves into the active settings when the load strobe rises. While the strobe stays high, every serial clock edge refreshes the settings from the shift register, so the register is transparent. When the strobe falls, the settings freeze. A diagnostic output shows one of four signals, chosen by the select bits. A range flag reports whether the active M is one the loop can lock to with a 25 MHz reference.

Top module: `divcfg_loader`

## Requirements
- R1: After synchronous reset, m_ctl = 28, n_ctl = 0, the select is 00, m_valid = 1 and test_out = 0.
- R2: While par_load_n is low, m_ctl and n_ctl follow par_m and par_n within a few system clocks.
- R3: When par_load_n rises, the last par_m/par_n values are held, and later changes on the parallel pins have no effect.
- R4: With par_load_n high and ser_load low, each rising ser_clk shifts ser_data into the shift register. Frame bit 13 goes in first and bit 0 goes in last. Bits 13:12 are the select {T1,T0}, bit 11 is filler, bits 10:9 are N and bits 8:0 are M. A rising ser_load copies the frame into the active settings.
- R5: The value of the filler bit (frame bit 11) has no effect on the loaded settings.
- R6: While ser_load is high, each rising ser_clk updates the active settings from the shift register, including the bit just shifted in.
- R7: With ser_load low, serial clocking never changes the active settings. The settings that were in place when ser_load fell stay in place.
- R8: test_out shows the following for each select value: 00 gives 0, 01 gives the synchronized ser_data, 10 gives fb_tap, 11 gives out_clk.
- R9: test_out is 0 while par_load_n is low. The select bits keep their value through parallel mode.
- R10: m_valid is 1 exactly when 25 ≤ m_ctl ≤ 31.
- R11: A serial load replaces parallel-captured settings, and a return to parallel mode replaces serial-loaded settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Active-low parallel enable; a rising edge captures the pins |
| par_m | input | 9 | Parallel feedback multiplier |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe |
| fb_tap | input | 1 | Feedback divider tap, routed to test_out for diagnostics |
| out_clk | input | 1 | Output clock, routed to test_out for diagnostics |
| m_ctl | output | 9 | Active feedback multiplier |
| n_ctl | output | 2 | Active output divide code |
| test_out | output | 1 | Diagnostic output |
| m_valid | output | 1 | Active M lies in the lockable range |

## Verification
Full frames are loaded with M just below, inside, at the top of and just above the lock range. This separates a frame decode that is off by one bit from a range compare that is off by one value. Two frames that differ only in the filler bit must give the same result. Serial bits are clocked with the strobe held high and checked after each edge, then clocked again after the strobe falls; this separates transparent loading from edge-only loading and from a freeze that never takes hold. Each select code is exercised with its chosen source toggled while the other sources are held at the opposite level. Parallel mode is entered both before and after a serial load to show which path owns the register.

// File: rtl/divcfg_pkg.sv
`timescale 1ns/1ps
package divcfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int PAD_W   = 1;
    localparam int FRAME_W = T_W + PAD_W + N_W + M_W;

    localparam logic [M_W-1:0] M_LOCK_MIN = M_W'(25);
    localparam logic [M_W-1:0] M_LOCK_MAX = M_W'(31);
    localparam logic [M_W-1:0] M_RESET    = M_W'(28);
    localparam logic [N_W-1:0] N_RESET    = '0;

    typedef enum logic [T_W-1:0] {
        TSEL_LOW   = 2'b00,
        TSEL_SDATA = 2'b01,
        TSEL_FBTAP = 2'b10,
        TSEL_OCLK  = 2'b11
    } tsel_e;

    typedef struct packed {
        tsel_e          tsel;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{tsel: TSEL_LOW, n: N_RESET, m: M_RESET};

    function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        cfg_t c;
        c.tsel = tsel_e'(f[FRAME_W-1 -: T_W]);
        c.n    = f[M_W +: N_W];
        c.m    = f[0 +: M_W];
        return c;
    endfunction

    function automatic logic m_lockable(input logic [M_W-1:0] m);
        return (m >= M_LOCK_MIN) && (m <= M_LOCK_MAX);
    endfunction
endpackage

// File: rtl/divcfg_sync.sv
`timescale 1ns/1ps
module divcfg_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/divcfg_shifter.sv
`timescale 1ns/1ps
module divcfg_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sr,
    output logic [W-1:0] sr_next
);
    assign sr_next = {sr[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= sr_next;
    end
endmodule

// File: rtl/divcfg_test_mux.sv
`timescale 1ns/1ps
module divcfg_test_mux
    import divcfg_pkg::*;
(
    input  tsel_e tsel,
    input  logic  par_mode,
    input  logic  sdata,
    input  logic  fb_tap,
    input  logic  out_clk,
    output logic  test_out
);
    logic sel_bit;

    always_comb begin
        unique case (tsel)
            TSEL_LOW:   sel_bit = 1'b0;
            TSEL_SDATA: sel_bit = sdata;
            TSEL_FBTAP: sel_bit = fb_tap;
            TSEL_OCLK:  sel_bit = out_clk;
        endcase
    end

    assign test_out = par_mode ? 1'b0 : sel_bit;
endmodule

// File: rtl/divcfg_loader.sv
`timescale 1ns/1ps
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           fb_tap,
    input  logic           out_clk,
    output logic [M_W-1:0] m_ctl,
    output logic [N_W-1:0] n_ctl,
    output logic           test_out,
    output logic           m_valid
);
    // synchronized {par_load_n, ser_load, ser_clk, ser_data}
    logic [3:0] sync_q;
    logic       pl_n_s, sload_s, sclk_s, sdata_s;
    logic [1:0] edge_prev;   // {ser_load, ser_clk} one clock later
    logic       sclk_rise, sload_rise, par_mode;
    logic [FRAME_W-1:0] sr, sr_next;
    cfg_t       cfg;

    divcfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) sync_i (
        .clk(clk), .rst(rst),
        .d({par_load_n, ser_load, ser_clk, ser_data}),
        .q(sync_q)
    );

    assign {pl_n_s, sload_s, sclk_s, sdata_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) edge_prev <= 2'b00;
        else     edge_prev <= {sload_s, sclk_s};
    end

    assign sclk_rise  = sclk_s  & ~edge_prev[0];
    assign sload_rise = sload_s & ~edge_prev[1];
    assign par_mode   = ~pl_n_s;

    divcfg_shifter #(.W(FRAME_W)) shift_i (
        .clk(clk), .rst(rst),
        .shift_en(pl_n_s & sclk_rise),
        .din(sdata_s),
        .sr(sr), .sr_next(sr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (par_mode) begin
            cfg.m <= par_m;
            cfg.n <= par_n;
        end else if (sload_s && sclk_rise) begin
            cfg <= frame_to_cfg(sr_next);
        end else if (sload_rise) begin
            cfg <= frame_to_cfg(sr);
        end
    end

    divcfg_test_mux mux_i (
        .tsel(cfg.tsel), .par_mode(par_mode), .sdata(sdata_s),
        .fb_tap(fb_tap), .out_clk(out_clk), .test_out(test_out)
    );

    assign m_ctl   = cfg.m;
    assign n_ctl   = cfg.n;
    assign m_valid = m_lockable(cfg.m);
endmodule

// File: rtl/divcfg_checker.sv
`timescale 1ns/1ps
module divcfg_checker
    import divcfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pl_n_s,
    input logic               sload_s,
    input logic               sclk_rise,
    input logic               sdata_s,
    input logic [FRAME_W-1:0] sr,
    input logic [M_W-1:0]     par_m,
    input logic [M_W-1:0]     m_ctl,
    input logic [N_W-1:0]     n_ctl,
    input logic               test_out,
    input logic               m_valid
);
    AST_PAR_TRACK: assert property (@(posedge clk) disable iff (rst)
        !pl_n_s |=> (m_ctl == $past(par_m)));                            // R2

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        (pl_n_s && sclk_rise) |=> (sr[0] == $past(sdata_s)));           // R4

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (pl_n_s && !sload_s) |=> ($stable(m_ctl) && $stable(n_ctl)));   // R7

    AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (rst)
        !pl_n_s |-> !test_out);                                          // R9

    AST_VALID_IN: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_ctl >= M_LOCK_MIN && m_ctl <= M_LOCK_MAX));       // R10

    AST_VALID_OUT: assert property (@(posedge clk) disable iff (rst)
        !m_valid |-> (m_ctl < M_LOCK_MIN || m_ctl > M_LOCK_MAX));        // R10
endmodule

bind divcfg_loader divcfg_checker chk_i (
    .clk(clk), .rst(rst), .pl_n_s(pl_n_s), .sload_s(sload_s),
    .sclk_rise(sclk_rise), .sdata_s(sdata_s), .sr(sr), .par_m(par_m),
    .m_ctl(m_ctl), .n_ctl(n_ctl), .test_out(test_out), .m_valid(m_valid)
);

// File: tb/divcfg_loader_tb_top.sv
`timescale 1ns/1ps
module divcfg_loader_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_load_n = 1'b1;
    logic [8:0] par_m = 9'd0;
    logic [1:0] par_n = 2'd0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic       fb_tap = 1'b0, out_clk = 1'b0;
    logic [8:0] m_ctl;
    logic [1:0] n_ctl;
    logic       test_out, m_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [13:0] msr = '0;   // bench model of the serial shift register

    typedef struct {
        logic [8:0] m;
        logic [1:0] n;
        logic       v;
        string      tag;
    } exp_t;
    exp_t sb_q [$];

    always #10 clk = ~clk;   // 50 MHz

    divcfg_loader dut_i (
        .clk(clk), .rst(rst), .par_load_n(par_load_n), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .fb_tap(fb_tap), .out_clk(out_clk),
        .m_ctl(m_ctl), .n_ctl(n_ctl), .test_out(test_out), .m_valid(m_valid)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_cfg(input logic [8:0] m, input logic [1:0] n, input string tag);
        exp_t e;
        e.m = m; e.n = n; e.v = (m >= 9'd25) && (m <= 9'd31); e.tag = tag;
        sb_q.push_back(e);
        cyc(2);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (m_ctl !== e.m || n_ctl !== e.n || m_valid !== e.v) begin
                    bad++;
                    $display("FAIL %s: got m=%0d n=%0d v=%0b exp m=%0d n=%0d v=%0b",
                             e.tag, m_ctl, n_ctl, m_valid, e.m, e.n, e.v);
                end
            end
        end
    end

    task automatic check_test(input logic exp, input string tag);
        cyc(4);
        total++;
        if (test_out !== exp) begin
            bad++;
            $display("FAIL %s: test_out got %0b exp %0b", tag, test_out, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        cyc(4);
        ser_clk = 1'b1;
        msr = {msr[12:0], b};
        cyc(4);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] t, input logic pad,
                              input logic [1:0] n, input logic [8:0] m);
        logic [13:0] f;
        f = {t, pad, n, m};
        for (int i = 13; i >= 0; i--) send_bit(f[i]);
        cyc(2);
    endtask

    task automatic load_pulse();
        ser_load = 1'b1;
        cyc(6);
        ser_load = 1'b0;
        cyc(6);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(4);
        expect_cfg(9'd28, 2'd0, "R1 reset defaults");
        check_test(1'b0, "R1 reset test_out");

        // parallel mode
        par_m = 9'd30; par_n = 2'd2; par_load_n = 1'b0;
        cyc(6);
        expect_cfg(9'd30, 2'd2, "R2 parallel pass-through");
        par_m = 9'd100; par_n = 2'd1;
        cyc(6);
        expect_cfg(9'd100, 2'd1, "R2 R10 parallel m out of range");
        par_m = 9'd27; par_n = 2'd1;
        cyc(6);
        par_load_n = 1'b1;
        cyc(6);
        par_m = 9'd5; par_n = 2'd3;
        cyc(6);
        expect_cfg(9'd27, 2'd1, "R3 capture on rising enable");

        // serial frames
        send_frame(2'b00, 1'b0, 2'd3, 9'd25);
        expect_cfg(9'd27, 2'd1, "R7 shifting without load");
        load_pulse();
        expect_cfg(9'd25, 2'd3, "R4 R11 serial frame over parallel capture");
        send_frame(2'b00, 1'b0, 2'd0, 9'd24);
        load_pulse();
        expect_cfg(9'd24, 2'd0, "R10 m just below range");
        send_frame(2'b00, 1'b0, 2'd2, 9'd31);
        load_pulse();
        expect_cfg(9'd31, 2'd2, "R10 m at top of range");
        send_frame(2'b00, 1'b0, 2'd1, 9'd32);
        load_pulse();
        expect_cfg(9'd32, 2'd1, "R10 m just above range");
        send_frame(2'b00, 1'b1, 2'd1, 9'd29);
        load_pulse();
        expect_cfg(9'd29, 2'd1, "R5 filler bit set");
        send_frame(2'b00, 1'b0, 2'd1, 9'd29);
        load_pulse();
        expect_cfg(9'd29, 2'd1, "R5 filler bit clear");

        // unloaded frame, then transparent mode
        send_frame(2'b00, 1'b0, 2'd2, 9'd26);
        expect_cfg(9'd29, 2'd1, "R7 frame held back without strobe");
        ser_load = 1'b1;
        cyc(6);
        expect_cfg(9'd26, 2'd2, "R4 strobe rise loads pending frame");
        begin
            logic [13:0] f;
            f = {2'b00, 1'b0, 2'd3, 9'd30};
            for (int i = 13; i >= 0; i--) begin
                send_bit(f[i]);
                cyc(2);
                expect_cfg(msr[8:0], msr[10:9], "R6 transparent update per bit");
            end
        end
        ser_load = 1'b0;
        cyc(6);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        cyc(4);
        expect_cfg(9'd30, 2'd3, "R7 frozen after strobe falls");

        // diagnostic output selections
        send_frame(2'b01, 1'b0, 2'd0, 9'd26);
        load_pulse();
        ser_data = 1'b0; check_test(1'b0, "R8 select 01 data low");
        ser_data = 1'b1; check_test(1'b1, "R8 select 01 data high");
        ser_data = 1'b0;
        send_frame(2'b10, 1'b0, 2'd0, 9'd26);
        load_pulse();
        ser_data = 1'b1; out_clk = 1'b1;
        fb_tap = 1'b1; check_test(1'b1, "R8 select 10 tap high");
        fb_tap = 1'b0; check_test(1'b0, "R8 select 10 tap low");
        ser_data = 1'b0; out_clk = 1'b0;
        send_frame(2'b11, 1'b0, 2'd0, 9'd26);
        load_pulse();
        ser_data = 1'b1; fb_tap = 1'b1;
        out_clk = 1'b1; check_test(1'b1, "R8 select 11 out_clk high");
        out_clk = 1'b0; check_test(1'b0, "R8 select 11 out_clk low");
        ser_data = 1'b0; fb_tap = 1'b0;
        send_frame(2'b00, 1'b0, 2'd0, 9'd26);
        load_pulse();
        ser_data = 1'b1; fb_tap = 1'b1; out_clk = 1'b1;
        check_test(1'b0, "R8 select 00 low");
        ser_data = 1'b0;

        // parallel mode after a serial load with select 11
        send_frame(2'b11, 1'b0, 2'd0, 9'd26);
        load_pulse();
        check_test(1'b1, "R8 select 11 before parallel");
        par_m = 9'd31; par_n = 2'd2; par_load_n = 1'b0;
        check_test(1'b0, "R9 parallel forces test low");
        cyc(2);
        expect_cfg(9'd31, 2'd2, "R11 parallel overrides serial load");
        par_load_n = 1'b1;
        check_test(1'b1, "R9 select kept through parallel mode");

        cyc(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule